// File: doc/BRIEF.md
# Burst DMA Channel Sequencer

This block runs a set of DMA channels that copy data between locations in external memory. Software programs a channel through a small register write port. It sets a source address, a destination address, a transfer count, and a control word. Setting the enable bit arms the channel. After a fixed arming delay, the channel asks for the bus. Once the bus is granted, it runs every transfer back to back. Each transfer is one external read followed by one external write, and the burst ends when the count is used up.

A channel can be set to give the bus away. In that case, when another master is waiting at the end of a transfer, the channel releases the bus and resumes once that master is finished. A channel that becomes ready while another channel is bursting waits until that burst ends. Several waiting channels are served lowest index first. An end-of-transfer strobe marks the final transfer. On completion, each channel clears its own enable and raises a sticky done flag.

Top module: `bdma_seq`

## Requirements
- R1: After the edge that accepts a control write with bit 0 (enable) set, a channel stays quiet for START_LAT cycles. With the grant returned in the same cycle as the request, its first read strobe appears in the cycle after edge START_LAT+2.
- R2: Each transfer is a read strobe at the source address, followed in the very next cycle by a write strobe at the destination address. The write carries the data returned by that read.
- R3: With control bit 1 (give-up) clear, a burst of N transfers occupies 2N consecutive strobe cycles, whatever the level of other_req.
- R4: With give-up set, if other_req is high during a non-final write, bus_req is low from the next cycle on. It stays low while other_req is high. The burst resumes with a read START two cycles after other_req falls. The bus is never released between a read and its write.
- R5: tend is high during both strobe cycles of the final transfer and during no other cycle.
- R6: When the final write completes, the channel's ch_en bit drops and its ch_done bit rises. A control write with bit 4 set clears ch_done.
- R7: A channel that becomes ready during another channel's burst keeps ch_en high and issues no strobe until that burst has finished.
- R8: Among channels that are waiting together, the lowest channel index is served first.
- R9: Register offset 0 holds the source address, 1 the destination address and 2 the transfer count. Control bits 2 and 3 make the source and destination advance by XFER_BYTES after each transfer; when a bit is clear, that address stays fixed.
- R10: Reset leaves ext_rd, ext_wr, bus_req, tend, ch_en and ch_done all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | CHW | Channel selected by the write |
| reg_addr | input | 2 | Register offset: 0 src, 1 dst, 2 count, 3 control |
| reg_wdata | input | AW | Write data |
| bus_req | output | 1 | Bus request to the system arbiter |
| bus_grant | input | 1 | Bus grant from the system arbiter |
| other_req | input | 1 | Another master wants the bus |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | AW | External address |
| ext_wdata | output | DW | External write data |
| ext_rdata | input | DW | External read data |
| tend | output | 1 | Final-transfer marker |
| ch_en | output | NCH | Per-channel armed/busy bits |
| ch_done | output | NCH | Per-channel sticky completion flags |

## Verification
The bench builds the block with three channels, so that two channels can wait on a third's burst. This makes it possible to observe both the holding of pending channels and the order in which they are served. START_LAT stays at 3 and XFER_BYTES at 2, which fixes the first-strobe cycle at an exact, checkable offset and makes address steps visible. The grant is tied back to the request, so the only delays in the strobe schedule come from the block itself.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
   typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_YLD} eng_st_t;
   localparam logic [1:0] RA_SRC = 2'd0;
   localparam logic [1:0] RA_DST = 2'd1;
   localparam logic [1:0] RA_CNT = 2'd2;
   localparam logic [1:0] RA_CTL = 2'd3;
   localparam int CB_EN   = 0;
   localparam int CB_GU   = 1;
   localparam int CB_SINC = 2;
   localparam int CB_DINC = 3;
   localparam int CB_CLR  = 4;
endpackage

// File: rtl/bdma_chan.sv
module bdma_chan
   import bdma_pkg::*;
#(
   parameter int AW        = 16,
   parameter int CW        = 16,
   parameter int START_LAT = 3,
   parameter int STEP      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_sel,
   input  logic [1:0]    wr_addr,
   input  logic [AW-1:0] wr_data,
   input  logic          adv,
   input  logic          fin,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [CW-1:0] cnt,
   output logic          gu,
   output logic          en,
   output logic          done,
   output logic          ready
);
   localparam int LW = $clog2(START_LAT + 1);

   logic          sinc, dinc;
   logic [LW-1:0] lat;

   assign ready = en && (lat == LW'(START_LAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src  <= '0;
         dst  <= '0;
         cnt  <= '0;
         gu   <= 1'b0;
         sinc <= 1'b0;
         dinc <= 1'b0;
         en   <= 1'b0;
         done <= 1'b0;
         lat  <= '0;
      end else begin
         if (en && lat != LW'(START_LAT)) lat <= lat + 1'b1;
         if (adv) begin
            cnt <= cnt - 1'b1;
            if (sinc) src <= src + AW'(STEP);
            if (dinc) dst <= dst + AW'(STEP);
         end
         if (fin) begin
            en   <= 1'b0;
            done <= 1'b1;
         end
         if (wr_sel) begin
            case (wr_addr)
               RA_SRC: src <= wr_data;
               RA_DST: dst <= wr_data;
               RA_CNT: cnt <= wr_data[CW-1:0];
               default: begin
                  gu   <= wr_data[CB_GU];
                  sinc <= wr_data[CB_SINC];
                  dinc <= wr_data[CB_DINC];
                  if (wr_data[CB_EN] && !en) begin
                     en  <= 1'b1;
                     lat <= '0;
                  end
                  if (wr_data[CB_CLR]) done <= 1'b0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/bdma_pick.sv
module bdma_pick #(
   parameter int NCH = 2,
   parameter int CHW = 1
) (
   input  logic [NCH-1:0] req,
   output logic           any,
   output logic [CHW-1:0] idx
);
   assign any = |req;
   generate
      if (NCH == 1) begin : g_single
         assign idx = '0;
      end else begin : g_prio
         always_comb begin
            idx = '0;
            for (int i = NCH - 1; i >= 0; i--) begin
               if (req[i]) idx = CHW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bdma_eng.sv
module bdma_eng
   import bdma_pkg::*;
#(
   parameter int CHW = 1,
   parameter int DW  = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           any,
   input  logic [CHW-1:0] pick,
   input  logic           bus_grant,
   input  logic           other_req,
   input  logic           cur_gu,
   input  logic           cur_last,
   input  logic [DW-1:0]  rdata,
   output logic [CHW-1:0] cur,
   output logic           bus_req,
   output logic           rd,
   output logic           wr,
   output logic           pair_done,
   output logic           fin,
   output logic           tend,
   output logic [DW-1:0]  wdata
);
   eng_st_t st;

   assign rd        = (st == ST_RD);
   assign wr        = (st == ST_WR);
   assign bus_req   = (st == ST_REQ) || rd || wr;
   assign pair_done = wr;
   assign fin       = wr && cur_last;
   assign tend      = (rd || wr) && cur_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cur   <= '0;
         wdata <= '0;
      end else begin
         case (st)
            ST_IDLE: if (any) begin
               cur <= pick;
               st  <= ST_REQ;
            end
            ST_REQ: if (bus_grant) st <= ST_RD;
            ST_RD: begin
               wdata <= rdata;
               st    <= ST_WR;
            end
            ST_WR: begin
               if (cur_last)                 st <= ST_IDLE;
               else if (cur_gu && other_req) st <= ST_YLD;
               else                          st <= ST_RD;
            end
            ST_YLD: if (!other_req) st <= ST_REQ;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bdma_seq.sv
module bdma_seq
   import bdma_pkg::*;
#(
   parameter int NCH        = 2,
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int CW         = 16,
   parameter int START_LAT  = 3,
   parameter int XFER_BYTES = 2,
   localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic [CHW-1:0] reg_ch,
   input  logic [1:0]     reg_addr,
   input  logic [AW-1:0]  reg_wdata,
   output logic           bus_req,
   input  logic           bus_grant,
   input  logic           other_req,
   output logic           ext_rd,
   output logic           ext_wr,
   output logic [AW-1:0]  ext_addr,
   output logic [DW-1:0]  ext_wdata,
   input  logic [DW-1:0]  ext_rdata,
   output logic           tend,
   output logic [NCH-1:0] ch_en,
   output logic [NCH-1:0] ch_done
);
   if (NCH < 1)       begin : g_bad_nch  $error("NCH must be at least 1");      end
   if (AW < CW)       begin : g_bad_aw   $error("AW must cover the count");     end
   if (AW < 5)        begin : g_bad_ctl  $error("AW too narrow for control");   end
   if (START_LAT < 3) begin : g_bad_lat  $error("START_LAT must be >= 3");      end
   if (XFER_BYTES < 1) begin : g_bad_step $error("XFER_BYTES must be >= 1");    end

   logic [NCH-1:0][AW-1:0] src_v, dst_v;
   logic [NCH-1:0][CW-1:0] cnt_v;
   logic [NCH-1:0]         gu_v, rdy_v;
   logic [CHW-1:0]         cur, pick;
   logic                   any, pair_done, fin, cur_gu, cur_last;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      bdma_chan #(
         .AW(AW), .CW(CW), .START_LAT(START_LAT), .STEP(XFER_BYTES)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_sel  (reg_wr && (reg_ch == CHW'(i))),
         .wr_addr (reg_addr),
         .wr_data (reg_wdata),
         .adv     (pair_done && (cur == CHW'(i))),
         .fin     (fin && (cur == CHW'(i))),
         .src     (src_v[i]),
         .dst     (dst_v[i]),
         .cnt     (cnt_v[i]),
         .gu      (gu_v[i]),
         .en      (ch_en[i]),
         .done    (ch_done[i]),
         .ready   (rdy_v[i])
      );
   end

   bdma_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
      .req (rdy_v),
      .any (any),
      .idx (pick)
   );

   assign cur_gu   = gu_v[cur];
   assign cur_last = (cnt_v[cur] == CW'(1));

   bdma_eng #(.CHW(CHW), .DW(DW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .any       (any),
      .pick      (pick),
      .bus_grant (bus_grant),
      .other_req (other_req),
      .cur_gu    (cur_gu),
      .cur_last  (cur_last),
      .rdata     (ext_rdata),
      .cur       (cur),
      .bus_req   (bus_req),
      .rd        (ext_rd),
      .wr        (ext_wr),
      .pair_done (pair_done),
      .fin       (fin),
      .tend      (tend),
      .wdata     (ext_wdata)
   );

   assign ext_addr = ext_wr ? dst_v[cur] : src_v[cur];
endmodule

// File: rtl/bdma_seq_chk.sv
module bdma_seq_chk #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ext_rd,
   input logic           ext_wr,
   input logic           bus_req,
   input logic           tend,
   input logic           other_req,
   input logic           cur_gu,
   input logic [NCH-1:0] ch_en
);
   a_r2_wr_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rd |=> ext_wr);
   a_r2_wr_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr |-> $past(ext_rd));
   a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_rd && ext_wr));
   a_r3_no_giveup_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr && !tend && !cur_gu) |=> ext_rd);
   a_r4_giveup_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr && !tend && cur_gu && other_req) |=> !bus_req);
   a_r4_no_release_mid_pair: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rd |=> bus_req);
   a_r5_tend_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      tend |-> (ext_rd || ext_wr));
   a_r5_tend_whole_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rd && tend) |=> (ext_wr && tend));
   a_r6_finish_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr && tend) |=> ($countones(ch_en) < $countones($past(ch_en))));
endmodule

bind bdma_seq bdma_seq_chk #(.NCH(NCH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_rd    (ext_rd),
   .ext_wr    (ext_wr),
   .bus_req   (bus_req),
   .tend      (tend),
   .other_req (other_req),
   .cur_gu    (cur_gu),
   .ch_en     (ch_en)
);

// File: tb/bdma_seq_test.sv
module bdma_seq_test;
   localparam int NCH = 3, AW = 16, DW = 16, LAT = 3, STEP = 2;
   localparam logic [15:0] KEY = 16'hA5C3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_ch = '0, reg_addr = '0;
   logic [AW-1:0] reg_wdata = '0;
   logic bus_req, bus_grant, other_req = 1'b0, ext_rd, ext_wr, tend;
   logic [AW-1:0] ext_addr;
   logic [DW-1:0] ext_wdata, ext_rdata;
   logic [NCH-1:0] ch_en, ch_done;

   int total = 0, bad = 0, cyc = 0, t_edge = 0;
   int nr = 0, nw = 0;
   logic [15:0] ra [64], wa [64], wd [64];
   int rt [64], wt [64];
   logic rtd [64], wtd [64];

   always #2 clk = ~clk;
   assign bus_grant = bus_req;
   assign ext_rdata = ext_addr ^ KEY;

   bdma_seq #(.NCH(NCH), .AW(AW), .DW(DW), .CW(16), .START_LAT(LAT), .XFER_BYTES(STEP)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_grant(bus_grant), .other_req(other_req),
      .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
      .ext_rdata(ext_rdata), .tend(tend), .ch_en(ch_en), .ch_done(ch_done));

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (ext_rd && nr < 64) begin
         ra[nr] = ext_addr; rt[nr] = cyc; rtd[nr] = tend; nr++;
      end
      if (ext_wr && nw < 64) begin
         wa[nw] = ext_addr; wd[nw] = ext_wdata; wt[nw] = cyc; wtd[nw] = tend; nw++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input int ch, input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_ch = 2'(ch); reg_addr = a; reg_wdata = d;
      t_edge = cyc + 1;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic setup(input int ch, input logic [15:0] s, input logic [15:0] d, input logic [15:0] n);
      wr_reg(ch, 2'd0, s);
      wr_reg(ch, 2'd1, d);
      wr_reg(ch, 2'd2, n);
   endtask

   task automatic wait_done(input logic [NCH-1:0] m);
      int k = 0;
      while (((ch_done & m) != m) && k < 500) begin
         @(negedge clk); k++;
      end
      chk(k < 500, "R6 completion", int'(ch_done), int'(m));
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_logs();
      nr = 0; nw = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk({ext_rd, ext_wr, bus_req, tend} == 4'b0, "R10 strobes idle", {ext_rd, ext_wr, bus_req, tend}, 0);
      chk(ch_en == '0 && ch_done == '0, "R10 flags clear", {ch_en, ch_done}, 0);
   endtask

   task automatic t_basic();
      int t0;
      clear_logs();
      setup(0, 16'h0100, 16'h0200, 16'd4);
      wr_reg(0, 2'd3, 16'h000D);
      t0 = t_edge;
      wait_done(3'b001);
      chk(rt[0] - t0 == LAT + 2, "R1 start latency", rt[0] - t0, LAT + 2);
      chk(nr == 4 && nw == 4, "R2 pair count", nr * 16 + nw, 16'h44);
      for (int i = 0; i < 4; i++) begin
         chk(ra[i] == 16'(16'h0100 + STEP * i), "R9 src step", ra[i], 16'h0100 + STEP * i);
         chk(wa[i] == 16'(16'h0200 + STEP * i), "R9 dst step", wa[i], 16'h0200 + STEP * i);
         chk(wd[i] == (ra[i] ^ KEY), "R2 data moved", wd[i], ra[i] ^ KEY);
         chk(wt[i] == rt[i] + 1, "R2 write follows read", wt[i], rt[i] + 1);
         chk(rtd[i] == (i == 3) && wtd[i] == (i == 3), "R5 tend placement", {rtd[i], wtd[i]}, (i == 3) ? 3 : 0);
      end
      chk(ch_en[0] == 1'b0 && ch_done[0] == 1'b1, "R6 enable off done on", {ch_en[0], ch_done[0]}, 1);
      wr_reg(0, 2'd3, 16'h0010);
      @(negedge clk);
      chk(ch_done[0] == 1'b0, "R6 done cleared", ch_done[0], 0);
   endtask

   task automatic t_hold_bus();
      clear_logs();
      setup(1, 16'h0400, 16'h0500, 16'd3);
      other_req = 1'b1;
      wr_reg(1, 2'd3, 16'h0001);
      wait_done(3'b010);
      other_req = 1'b0;
      chk(nr == 3, "R3 reads", nr, 3);
      for (int i = 0; i < 3; i++) begin
         chk(ra[i] == 16'h0400 && wa[i] == 16'h0500, "R9 fixed addresses", {ra[i][11:8], wa[i][11:8]}, 8'h45);
         if (i < 2) chk(rt[i + 1] == wt[i] + 1, "R3 back to back despite other_req", rt[i + 1], wt[i] + 1);
      end
      wr_reg(1, 2'd3, 16'h0010);
   endtask

   task automatic t_yield();
      int k = 0;
      clear_logs();
      setup(0, 16'h0600, 16'h0700, 16'd3);
      wr_reg(0, 2'd3, 16'h000F);
      while (!ext_wr && k < 100) begin @(negedge clk); k++; end
      chk(bus_req == 1'b1, "R4 bus held in first pair", bus_req, 1);
      other_req = 1'b1;
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         chk(bus_req == 1'b0 && !ext_rd, "R4 bus released", bus_req, 0);
      end
      other_req = 1'b0;
      wait_done(3'b001);
      chk(nr == 3 && nw == 3, "R4 all pairs done", nr * 16 + nw, 16'h33);
      chk(rt[1] == wt[0] + 6, "R4 resume timing", rt[1] - wt[0], 6);
      chk(rt[2] == wt[1] + 1, "R4 no yield once request drops", rt[2] - wt[1], 1);
      for (int i = 0; i < 3; i++) chk(wt[i] == rt[i] + 1, "R4 pair not split", wt[i] - rt[i], 1);
      wr_reg(0, 2'd3, 16'h0010);
   endtask

   task automatic t_pending();
      int k = 0;
      logic [15:0] exp_a;
      clear_logs();
      setup(0, 16'h1000, 16'h1800, 16'd2);
      setup(1, 16'h2000, 16'h2800, 16'd2);
      setup(2, 16'h3000, 16'h3800, 16'd6);
      wr_reg(2, 2'd3, 16'h000D);
      while (!ext_rd && k < 100) begin @(negedge clk); k++; end
      wr_reg(1, 2'd3, 16'h000D);
      wr_reg(0, 2'd3, 16'h000D);
      repeat (LAT + 1) @(negedge clk);
      chk(ch_en == 3'b111 && tend == 1'b0, "R7 others pending during burst", ch_en, 3'b111);
      wait_done(3'b111);
      chk(nr == 10, "R7 total reads", nr, 10);
      for (int i = 0; i < 10; i++) begin
         exp_a = (i < 6) ? 16'(16'h3000 + STEP * i) :
                 (i < 8) ? 16'(16'h1000 + STEP * (i - 6)) : 16'(16'h2000 + STEP * (i - 8));
         chk(ra[i] == exp_a, (i < 6) ? "R7 active channel first" : "R8 lowest index first", ra[i], exp_a);
      end
      chk(rt[6] > wt[5], "R7 starts after burst ends", rt[6], wt[5] + 1);
   endtask

   initial begin
      #(200000 * 4);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_hold_bus();
      t_yield();
      t_pending();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule